// File: doc/BRIEF.md
# Spare Line Repair Allocator

This block sits beside a memory self-test engine and decides how the spare lines of each memory instance are spent. Every memory instance owns one spare row group and one spare column group. Each group replaces a fixed number of physically adjacent lines at once. The self-test engine reports each failing cell as an instance number plus the physical row and column of the cell. The engine translates logical addresses to physical positions before it sends a report, so every decision here works in physical coordinates.

When a report arrives, the block first checks it against the full physical span of any spare group already committed for that instance. A cell inside a replaced span costs nothing. An uncovered cell takes the free row group first and the free column group second. If neither group is free, the instance is marked unrepairable. The committed groups, with their base lines, are held in registers for readout. A done flag records that the test engine has finished. A synchronous clear returns the whole block to its empty state.

Top module: `rap_repair_alloc`

## Requirements
- R1: After asynchronous reset, and one cycle after a synchronous `clr`, every valid bit, every fail bit and `done` read 0. `clr` takes priority over a fault report or `test_end` in the same cycle.
- R2: The first uncovered fault on an instance with a free row group sets that instance's `row_vld` one cycle later. `row_base` becomes the fault row with its low log2(ROW_SPAN) bits cleared.
- R3: An uncovered fault on an instance whose row group is taken but whose column group is free sets `col_vld` one cycle later. `col_base` becomes the fault column with its low log2(COL_SPAN) bits cleared.
- R4: A fault is covered when its row lies in [row_base, row_base+ROW_SPAN-1] of a valid row group, or its column lies in [col_base, col_base+COL_SPAN-1] of a valid column group. A covered fault changes no output.
- R5: An uncovered fault on an instance whose two groups are both taken sets that instance's `rep_fail` bit one cycle later.
- R6: Once set, a `rep_fail` bit stays 1 until `clr`.
- R7: Once a group is valid, its valid bit and its base stay unchanged until `clr`. `col_vld` is never 1 while the same instance's `row_vld` is 0.
- R8: A fault report for instance k changes only the outputs of instance k.
- R9: A `test_end` pulse sets `done` one cycle later. `done` then stays 1 until `clr`.
- R10: While `flt_valid` is 0, the values on `flt_inst`, `flt_row` and `flt_col` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all allocation state |
| test_end | input | 1 | Pulse from the test engine when the test is finished |
| flt_valid | input | 1 | A fault report is present this cycle |
| flt_inst | input | INST_W | Memory instance of the failing cell |
| flt_row | input | ROW_W | Physical row of the failing cell |
| flt_col | input | COL_W | Physical column of the failing cell |
| row_vld | output | NUM_INST | Per instance: the spare row group is committed |
| row_base | output | NUM_INST*ROW_W | Per instance: first physical row replaced (instance k at bits k*ROW_W upward) |
| col_vld | output | NUM_INST | Per instance: the spare column group is committed |
| col_base | output | NUM_INST*COL_W | Per instance: first physical column replaced (instance k at bits k*COL_W upward) |
| rep_fail | output | NUM_INST | Per instance: a fault could not be repaired |
| done | output | 1 | The test engine has finished |

## Verification
The assertions assume the fault row and column are physical positions within ROW_W and COL_W bits. They also assume `flt_inst` names an existing instance whenever `flt_valid` is high. The bench only draws instance numbers below NUM_INST, and the default NUM_INST is a power of two, so every instance code is legal. The random phase keeps rows and columns in a narrow window so that covered and uncovered faults, and exhausted instances, all occur often.

// File: rtl/rap_pkg.sv
package rap_pkg;

    // Outcome of one fault report for a single instance
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_ROW  = 2'd1,
        ACT_COL  = 2'd2,
        ACT_FAIL = 2'd3
    } rap_act_e;

endpackage

// File: rtl/rap_span_match.sv
// Decides whether a line index falls inside the aligned span of a committed group.
module rap_span_match #(
    parameter int IDX_W = 8,
    parameter int SPAN  = 4
) (
    input  logic             vld,
    input  logic [IDX_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    localparam int LSB = (SPAN > 1) ? $clog2(SPAN) : 0;
    localparam logic [IDX_W-1:0] HI_MASK = {IDX_W{1'b1}} << LSB;

    generate
        if (SPAN == 1) begin : g_single
            assign hit = vld && (idx == base);
        end else begin : g_group
            assign hit = vld && ((idx & HI_MASK) == (base & HI_MASK));
        end
    endgenerate
endmodule

// File: rtl/rap_policy.sv
// Allocation priority: covered -> nothing, then row group, then column group, then fail.
module rap_policy
    import rap_pkg::*;
(
    input  logic     fire,
    input  logic     row_hit,
    input  logic     col_hit,
    input  logic     row_used,
    input  logic     col_used,
    output rap_act_e act
);
    always_comb begin
        act = ACT_NONE;
        if (fire && !(row_hit || col_hit)) begin
            if (!row_used)      act = ACT_ROW;
            else if (!col_used) act = ACT_COL;
            else                act = ACT_FAIL;
        end
    end
endmodule

// File: rtl/rap_slot.sv
// Allocation state of one memory instance.
module rap_slot
    import rap_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int COL_W    = 6,
    parameter int ROW_SPAN = 4,
    parameter int COL_SPAN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sel,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             row_vld,
    output logic [ROW_W-1:0] row_base,
    output logic             col_vld,
    output logic [COL_W-1:0] col_base,
    output logic             fail
);
    localparam int ROW_LSB = (ROW_SPAN > 1) ? $clog2(ROW_SPAN) : 0;
    localparam int COL_LSB = (COL_SPAN > 1) ? $clog2(COL_SPAN) : 0;
    localparam logic [ROW_W-1:0] ROW_ALIGN = {ROW_W{1'b1}} << ROW_LSB;
    localparam logic [COL_W-1:0] COL_ALIGN = {COL_W{1'b1}} << COL_LSB;

    typedef struct packed {
        logic             rv;
        logic [ROW_W-1:0] rb;
        logic             cv;
        logic [COL_W-1:0] cb;
        logic             fl;
    } slot_t;

    slot_t    st_d, st_q;
    logic     row_hit, col_hit;
    rap_act_e act;

    rap_span_match #(.IDX_W(ROW_W), .SPAN(ROW_SPAN)) u_row_span (
        .vld (st_q.rv),
        .base(st_q.rb),
        .idx (row),
        .hit (row_hit)
    );

    rap_span_match #(.IDX_W(COL_W), .SPAN(COL_SPAN)) u_col_span (
        .vld (st_q.cv),
        .base(st_q.cb),
        .idx (col),
        .hit (col_hit)
    );

    rap_policy u_policy (
        .fire    (sel),
        .row_hit (row_hit),
        .col_hit (col_hit),
        .row_used(st_q.rv),
        .col_used(st_q.cv),
        .act     (act)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            case (act)
                ACT_ROW: begin
                    st_d.rv = 1'b1;
                    st_d.rb = row & ROW_ALIGN;
                end
                ACT_COL: begin
                    st_d.cv = 1'b1;
                    st_d.cb = col & COL_ALIGN;
                end
                ACT_FAIL: st_d.fl = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_vld  = st_q.rv;
    assign row_base = st_q.rb;
    assign col_vld  = st_q.cv;
    assign col_base = st_q.cb;
    assign fail     = st_q.fl;
endmodule

// File: rtl/rap_repair_alloc.sv
module rap_repair_alloc #(
    parameter int NUM_INST = 4,
    parameter int ROW_W    = 8,
    parameter int COL_W    = 6,
    parameter int ROW_SPAN = 4,
    parameter int COL_SPAN = 2,
    parameter int INST_W   = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      test_end,
    input  logic                      flt_valid,
    input  logic [INST_W-1:0]         flt_inst,
    input  logic [ROW_W-1:0]          flt_row,
    input  logic [COL_W-1:0]          flt_col,
    output logic [NUM_INST-1:0]       row_vld,
    output logic [NUM_INST*ROW_W-1:0] row_base,
    output logic [NUM_INST-1:0]       col_vld,
    output logic [NUM_INST*COL_W-1:0] col_base,
    output logic [NUM_INST-1:0]       rep_fail,
    output logic                      done
);
    typedef struct packed {
        logic dn;
    } top_t;

    top_t                top_d, top_q;
    logic [NUM_INST-1:0] sel;

    generate
        for (genvar k = 0; k < NUM_INST; k++) begin : g_slot
            assign sel[k] = flt_valid && (flt_inst == INST_W'(k));

            rap_slot #(
                .ROW_W   (ROW_W),
                .COL_W   (COL_W),
                .ROW_SPAN(ROW_SPAN),
                .COL_SPAN(COL_SPAN)
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr),
                .sel     (sel[k]),
                .row     (flt_row),
                .col     (flt_col),
                .row_vld (row_vld[k]),
                .row_base(row_base[k*ROW_W +: ROW_W]),
                .col_vld (col_vld[k]),
                .col_base(col_base[k*COL_W +: COL_W]),
                .fail    (rep_fail[k])
            );
        end
    endgenerate

    always_comb begin
        top_d = top_q;
        if (clr)           top_d.dn = 1'b0;
        else if (test_end) top_d.dn = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign done = top_q.dn;
endmodule

// File: rtl/rap_repair_alloc_chk.sv
module rap_repair_alloc_chk #(
    parameter int NUM_INST = 4,
    parameter int ROW_W    = 8,
    parameter int COL_W    = 6,
    parameter int ROW_SPAN = 4,
    parameter int COL_SPAN = 2,
    parameter int INST_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      clr,
    input logic                      test_end,
    input logic                      flt_valid,
    input logic [INST_W-1:0]         flt_inst,
    input logic [ROW_W-1:0]          flt_row,
    input logic [COL_W-1:0]          flt_col,
    input logic [NUM_INST-1:0]       row_vld,
    input logic [NUM_INST*ROW_W-1:0] row_base,
    input logic [NUM_INST-1:0]       col_vld,
    input logic [NUM_INST*COL_W-1:0] col_base,
    input logic [NUM_INST-1:0]       rep_fail,
    input logic                      done
);
    localparam logic [ROW_W-1:0] RLOW = ROW_W'(ROW_SPAN - 1);
    localparam logic [COL_W-1:0] CLOW = COL_W'(COL_SPAN - 1);

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (row_vld == '0) && (col_vld == '0) && (rep_fail == '0) && !done); // R1

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (test_end && !clr) |=> done); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done); // R9

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_valid && !clr) |=> $stable(row_vld) && $stable(col_vld) && $stable(rep_fail)); // R10

    generate
        for (genvar k = 0; k < NUM_INST; k++) begin : g_chk
            AST_ROW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
                row_vld[k] |-> ((row_base[k*ROW_W +: ROW_W] & RLOW) == '0)); // R2

            AST_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
                col_vld[k] |-> ((col_base[k*COL_W +: COL_W] & CLOW) == '0)); // R3

            AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
                col_vld[k] |-> row_vld[k]); // R7

            AST_FAIL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
                rep_fail[k] |-> (row_vld[k] && col_vld[k])); // R5

            AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (rep_fail[k] && !clr) |=> rep_fail[k]); // R6

            AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (row_vld[k] && !clr) |=> row_vld[k] && $stable(row_base[k*ROW_W +: ROW_W])); // R7

            AST_COL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (col_vld[k] && !clr) |=> col_vld[k] && $stable(col_base[k*COL_W +: COL_W])); // R7

            AST_ROW_COVER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
                (flt_valid && flt_inst == INST_W'(k) && !clr && row_vld[k] &&
                 ((flt_row & ~RLOW) == row_base[k*ROW_W +: ROW_W]))
                |=> $stable(col_vld[k]) && $stable(rep_fail[k])); // R4

            AST_OTHER_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && !(flt_valid && flt_inst == INST_W'(k)))
                |=> $stable(row_vld[k]) && $stable(col_vld[k]) && $stable(rep_fail[k])); // R8
        end
    endgenerate
endmodule

bind rap_repair_alloc rap_repair_alloc_chk #(
    .NUM_INST(NUM_INST),
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .ROW_SPAN(ROW_SPAN),
    .COL_SPAN(COL_SPAN),
    .INST_W  (INST_W)
) u_chk (.*);

// File: tb/rap_repair_alloc_tb.sv
module rap_repair_alloc_tb;
    localparam int NI = 4;
    localparam int RW = 8;
    localparam int CW = 6;
    localparam int RS = 4;
    localparam int CS = 2;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              test_end = 1'b0;
    logic              flt_valid = 1'b0;
    logic [IW-1:0]     flt_inst = '0;
    logic [RW-1:0]     flt_row = '0;
    logic [CW-1:0]     flt_col = '0;
    logic [NI-1:0]     row_vld, col_vld, rep_fail;
    logic [NI*RW-1:0]  row_base;
    logic [NI*CW-1:0]  col_base;
    logic              done;

    int n_chk = 0;
    int n_err = 0;

    // reference state
    int m_rv [NI];
    int m_rb [NI];
    int m_cv [NI];
    int m_cb [NI];
    int m_fl [NI];
    int m_dn;

    always #2.5 clk = ~clk;

    rap_repair_alloc #(
        .NUM_INST(NI), .ROW_W(RW), .COL_W(CW), .ROW_SPAN(RS), .COL_SPAN(CS), .INST_W(IW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .test_end(test_end),
        .flt_valid(flt_valid), .flt_inst(flt_inst), .flt_row(flt_row), .flt_col(flt_col),
        .row_vld(row_vld), .row_base(row_base), .col_vld(col_vld), .col_base(col_base),
        .rep_fail(rep_fail), .done(done)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < NI; k++) begin
            m_rv[k] = 0; m_rb[k] = 0; m_cv[k] = 0; m_cb[k] = 0; m_fl[k] = 0;
        end
        m_dn = 0;
    endtask

    task automatic compare_all(string tag);
        for (int k = 0; k < NI; k++) begin
            chk(tag, $sformatf("row_vld[%0d]", k), 32'(row_vld[k]), 32'(m_rv[k]));
            chk(tag, $sformatf("col_vld[%0d]", k), 32'(col_vld[k]), 32'(m_cv[k]));
            chk(tag, $sformatf("rep_fail[%0d]", k), 32'(rep_fail[k]), 32'(m_fl[k]));
            if (m_rv[k] != 0)
                chk(tag, $sformatf("row_base[%0d]", k), 32'(row_base[k*RW +: RW]), 32'(m_rb[k]));
            if (m_cv[k] != 0)
                chk(tag, $sformatf("col_base[%0d]", k), 32'(col_base[k*CW +: CW]), 32'(m_cb[k]));
        end
        chk(tag, "done", 32'(done), 32'(m_dn));
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic cyc(bit v, int inst, int row, int col, bit te, bit cl, string tag);
        flt_valid = v; flt_inst = IW'(inst); flt_row = RW'(row); flt_col = CW'(col);
        test_end = te; clr = cl;
        @(posedge clk);
        if (cl) begin
            model_clear();
        end else begin
            if (te) m_dn = 1;
            if (v) begin
                bit rh, ch;
                rh = (m_rv[inst] != 0) && row >= m_rb[inst] && row < m_rb[inst] + RS;
                ch = (m_cv[inst] != 0) && col >= m_cb[inst] && col < m_cb[inst] + CS;
                if (!(rh || ch)) begin
                    if (m_rv[inst] == 0) begin
                        m_rv[inst] = 1; m_rb[inst] = row - (row % RS);
                    end else if (m_cv[inst] == 0) begin
                        m_cv[inst] = 1; m_cb[inst] = col - (col % CS);
                    end else begin
                        m_fl[inst] = 1;
                    end
                end
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");

        // idle with garbage on the fault fields
        cyc(0, 1, 8'h55, 6'h2A, 0, 0, "R10");
        cyc(0, 0, 8'h13, 6'h01, 0, 0, "R10");

        // first fault on instance 0 takes the row group
        cyc(1, 0, 8'h37, 6'h05, 0, 0, "R2");
        chk("R2", "row_base[0] abs", 32'(row_base[7:0]), 32'h34);
        chk("R3", "col_vld[0] abs", 32'(col_vld[0]), 32'd0);

        // span edges of the row group are covered
        cyc(1, 0, 8'h34, 6'h09, 0, 0, "R4");
        cyc(1, 0, 8'h37, 6'h11, 0, 0, "R4");
        chk("R4", "col_vld[0] after covered", 32'(col_vld[0]), 32'd0);

        // just past the row span: column group
        cyc(1, 0, 8'h38, 6'h09, 0, 0, "R3");
        chk("R3", "col_base[0] abs", 32'(col_base[5:0]), 32'h08);

        // column span edges covered
        cyc(1, 0, 8'h10, 6'h08, 0, 0, "R4");
        cyc(1, 0, 8'h90, 6'h09, 0, 0, "R4");
        chk("R4", "rep_fail[0] after covered", 32'(rep_fail[0]), 32'd0);

        // uncovered with both used
        cyc(1, 0, 8'h10, 6'h0A, 0, 0, "R5");
        chk("R5", "rep_fail[0] abs", 32'(rep_fail[0]), 32'd1);
        cyc(0, 0, 0, 0, 0, 0, "R6");
        cyc(1, 0, 8'h35, 6'h00, 0, 0, "R6");
        cyc(1, 0, 8'hF0, 6'h3F, 0, 0, "R7");
        chk("R7", "row_base[0] held", 32'(row_base[7:0]), 32'h34);

        // other instances independent
        cyc(1, 2, 8'h03, 6'h3F, 0, 0, "R8");
        chk("R8", "row_vld abs", 32'(row_vld), 32'b0101);
        chk("R8", "row_base[2] abs", 32'(row_base[23:16]), 32'h00);

        // done
        cyc(0, 0, 0, 0, 1, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, "R9");
        chk("R9", "done abs", 32'(done), 32'd1);

        // clear wins over a same-cycle fault and test_end
        cyc(1, 1, 8'h22, 6'h22, 1, 1, "R1");
        chk("R1", "row_vld after clr", 32'(row_vld), 32'd0);

        // random phase
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 2)
                cyc(0, 0, 0, 0, 0, 1, "R1");
            else if (r < 5)
                cyc(0, 0, 0, 0, 1, 0, "R9");
            else if (r < 20)
                cyc(0, int'($urandom_range(0, NI-1)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 63)), 0, 0, "R10");
            else
                cyc(1, int'($urandom_range(0, NI-1)), int'($urandom_range(8'h20, 8'h2F)),
                    int'($urandom_range(6'h10, 6'h17)), 0, 0, "R7");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule